// File: doc/BRIEF.md
# Receive Special Character Filter

This block sits on the path from a UART receiver's deserializer to its receive FIFO and classifies every received character in the cycle it arrives. It compares the byte against four programmable match values: a first on/off pair and a second on/off pair. From that comparison it decides three things:

- whether the byte is pushed into the FIFO;
- whether a special-character interrupt is flagged;
- whether a software flow-control event (stop or resume) takes place. A stop or resume event sets or clears a request to halt the local transmitter.

A 2-bit compare mode picks which on/off pair acts as flow control. Value 2'b10 selects the first pair and value 2'b01 selects the second pair. Values 2'b00 and 2'b11 turn software flow control off. Special-character detection has its own enable. It always compares against the second-pair stop value.

When the second pair is in use, that same stop value is a flow character. It is therefore kept out of the FIFO, and it raises both the stop interrupt and, if detection is enabled, the special-character interrupt. All interrupt flags are sticky until a one-cycle clear pulse.

Top module: `spec_char_filter`

## Requirements
- R1: After reset, irq_special, irq_xoff, irq_xon and tx_halt are all 0, and push is 0 while rx_valid is 0.
- R2: A strobed byte that is not a flow character for the current mode asserts push in the same cycle as rx_valid, with push_data equal to rx_data.
- R3: With spec_en = 1, a strobed byte equal to xoff2_val sets irq_special at the next clock edge. Under modes 2'b00, 2'b10 and 2'b11 that byte is also pushed.
- R4: With spec_en = 0, irq_special is never set.
- R5: Matching compares all DATA_W bits, bit 0 being the first bit received. A byte that differs from a match value only in bit 0 does not match.
- R6: Under mode 2'b01, a strobed byte equal to xoff2_val is not pushed. It sets irq_xoff and tx_halt at the next edge, and it also sets irq_special when spec_en = 1.
- R7: Under mode 2'b01, a strobed byte equal to xon2_val is not pushed. It sets irq_xon and clears tx_halt at the next edge.
- R8: Under mode 2'b10, xoff1_val and xon1_val act as in R6 and R7 (without the special flag) and are not pushed. Under mode 2'b01, the first-pair values are ordinary bytes.
- R9: Each interrupt flag stays set until irq_clr is 1 at a clock edge. If a clear and a new set arrive in the same cycle, the flag stays set.
- R10: Strobes on consecutive cycles each receive their own same-cycle push decision, so no character is lost.
- R11: Under modes 2'b00 and 2'b11, every strobed byte is pushed and tx_halt does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received-byte strobe from the deserializer |
| rx_data | input | DATA_W | Received byte |
| spec_en | input | 1 | Special-character detection enable |
| flow_mode | input | 2 | 01 = second pair, 10 = first pair, 00/11 = off |
| xon1_val | input | DATA_W | First-pair resume value |
| xoff1_val | input | DATA_W | First-pair stop value |
| xon2_val | input | DATA_W | Second-pair resume value |
| xoff2_val | input | DATA_W | Second-pair stop and special value |
| irq_clr | input | 1 | One-cycle pulse clearing all interrupt flags |
| push | output | 1 | FIFO write strobe |
| push_data | output | DATA_W | FIFO write data |
| irq_special | output | 1 | Sticky special-character flag |
| irq_xoff | output | 1 | Sticky stop-received flag |
| irq_xon | output | 1 | Sticky resume-received flag |
| tx_halt | output | 1 | Request to hold the transmitter |

## Verification
The bench builds the block with the default DATA_W of 8, the width of a real character. This lets the match values be chosen so that they differ from test bytes only in bit 0 or only in bit 7, which exercises both ends of the comparison. With these values, each mode's flow pair can be applied while the other pair's values are presented as ordinary bytes. This shows that only the selected pair is decoded. A run of back-to-back strobes and a clear arriving together with a new set cover the cycle-level corner cases.

// File: rtl/spec_char_filter.sv
module spec_char_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              spec_en,
  input  logic [1:0]        flow_mode,
  input  logic [DATA_W-1:0] xon1_val,
  input  logic [DATA_W-1:0] xoff1_val,
  input  logic [DATA_W-1:0] xon2_val,
  input  logic [DATA_W-1:0] xoff2_val,
  input  logic              irq_clr,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              irq_special,
  output logic              irq_xoff,
  output logic              irq_xon,
  output logic              tx_halt
);
  localparam logic [1:0] MODE_PAIR2 = 2'b01;
  localparam logic [1:0] MODE_PAIR1 = 2'b10;

  logic use1, use2, hit_off, hit_on, hit_spec;

  assign use1     = (flow_mode == MODE_PAIR1);
  assign use2     = (flow_mode == MODE_PAIR2);
  assign hit_off  = (use1 && rx_data == xoff1_val) || (use2 && rx_data == xoff2_val);
  assign hit_on   = (use1 && rx_data == xon1_val)  || (use2 && rx_data == xon2_val);
  assign hit_spec = spec_en && (rx_data == xoff2_val);

  assign push      = rx_valid && !hit_off && !hit_on;
  assign push_data = rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_special <= 1'b0;
      irq_xoff    <= 1'b0;
      irq_xon     <= 1'b0;
      tx_halt     <= 1'b0;
    end else begin
      irq_special <= (irq_special && !irq_clr) || (rx_valid && hit_spec);
      irq_xoff    <= (irq_xoff && !irq_clr)    || (rx_valid && hit_off);
      irq_xon     <= (irq_xon && !irq_clr)     || (rx_valid && hit_on && !hit_off);
      if (rx_valid && hit_off)
        tx_halt <= 1'b1;
      else if (rx_valid && hit_on)
        tx_halt <= 1'b0;
    end
  end
endmodule

module spec_char_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              spec_en,
  input logic [1:0]        flow_mode,
  input logic [DATA_W-1:0] xon2_val,
  input logic [DATA_W-1:0] xoff2_val,
  input logic              irq_clr,
  input logic              push,
  input logic [DATA_W-1:0] push_data,
  input logic              irq_special,
  input logic              tx_halt
);
  AST_PUSH_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> rx_valid); // R10
  AST_PUSH_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> push_data == rx_data); // R2
  AST_XOFF2_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && flow_mode == 2'b01 && rx_data == xoff2_val) |-> !push); // R6
  AST_XOFF2_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && flow_mode == 2'b01 && rx_data == xoff2_val) |=> tx_halt); // R6
  AST_XON2_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && flow_mode == 2'b01 && rx_data == xon2_val && rx_data != xoff2_val) |=> !tx_halt); // R7
  AST_SPECIAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && spec_en && rx_data == xoff2_val) |=> irq_special); // R3
  AST_SPECIAL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_special) |-> $past(rx_valid && spec_en)); // R4
  AST_SPECIAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_special && !irq_clr) |=> irq_special); // R9
  AST_MODE_OFF_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && flow_mode[1] == flow_mode[0]) |-> push); // R11
  AST_MODE_OFF_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode[1] == flow_mode[0]) |=> $stable(tx_halt)); // R11
endmodule

bind spec_char_filter spec_char_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .spec_en(spec_en), .flow_mode(flow_mode), .xon2_val(xon2_val),
  .xoff2_val(xoff2_val), .irq_clr(irq_clr), .push(push),
  .push_data(push_data), .irq_special(irq_special), .tx_halt(tx_halt)
);

// File: tb/spec_char_filter_test.sv
`timescale 1ns/1ps
module spec_char_filter_test;
  localparam int DATA_W = 8;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic spec_en = 1'b0;
  logic [1:0] flow_mode = 2'b00;
  logic [DATA_W-1:0] xon1_val = 8'h11, xoff1_val = 8'h13;
  logic [DATA_W-1:0] xon2_val = 8'h91, xoff2_val = 8'h93;
  logic irq_clr = 1'b0;
  logic push, irq_special, irq_xoff, irq_xon, tx_halt;
  logic [DATA_W-1:0] push_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spec_char_filter #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .spec_en(spec_en), .flow_mode(flow_mode), .xon1_val(xon1_val),
    .xoff1_val(xoff1_val), .xon2_val(xon2_val), .xoff2_val(xoff2_val),
    .irq_clr(irq_clr), .push(push), .push_data(push_data),
    .irq_special(irq_special), .irq_xoff(irq_xoff), .irq_xon(irq_xon),
    .tx_halt(tx_halt)
  );

  // {spec_en, mode, byte, push, special, xoff, xon, halt}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 8'h41, 5'b10000},  // R2
    {1'b1, 2'b00, 8'h93, 5'b11000},  // R3
    {1'b0, 2'b00, 8'h93, 5'b10000},  // R4
    {1'b1, 2'b00, 8'h92, 5'b10000},  // R5 bit 0 differs
    {1'b1, 2'b01, 8'h93, 5'b01101},  // R6
    {1'b1, 2'b01, 8'h91, 5'b00010},  // R7
    {1'b0, 2'b01, 8'h93, 5'b00101},  // R6 without special
    {1'b0, 2'b01, 8'h13, 5'b10001},  // R8 first pair ordinary
    {1'b0, 2'b01, 8'h91, 5'b00010},  // R7
    {1'b1, 2'b10, 8'h13, 5'b00101},  // R8 stop
    {1'b1, 2'b10, 8'h93, 5'b11001},  // R3 R8 special stored
    {1'b0, 2'b10, 8'h11, 5'b00010},  // R8 resume
    {1'b0, 2'b11, 8'h13, 5'b10000},  // R11
    {1'b1, 2'b00, 8'h13, 5'b10000}   // R11 / R5 bit 7 differs from 93
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags", {irq_special, irq_xoff, irq_xon, tx_halt, push}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {irq_special, irq_xoff, irq_xon, tx_halt, push}, 5'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      irq_clr = 1'b1; rx_valid = 1'b0;
      @(negedge clk);
      irq_clr = 1'b0;
      spec_en = VEC[i][15]; flow_mode = VEC[i][14:13]; rx_data = VEC[i][12:5];
      rx_valid = 1'b1;
      #0.5;
      chk($sformatf("R2/R10 push vec%0d", i), push, VEC[i][4]);
      if (VEC[i][4]) chk($sformatf("R2 data vec%0d", i), push_data, VEC[i][12:5]);
      @(negedge clk);
      rx_valid = 1'b0;
      chk($sformatf("R3/R4/R6/R7/R8 flags vec%0d", i), {irq_special, irq_xoff, irq_xon}, VEC[i][3:1]);
      chk($sformatf("R6/R7/R11 halt vec%0d", i), tx_halt, VEC[i][0]);
    end

    // R9: sticky, then clear colliding with a new set
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; spec_en = 1'b1; flow_mode = 2'b00; rx_data = 8'h93; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 sticky", irq_special, 1'b1);
    irq_clr = 1'b1; rx_valid = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; rx_valid = 1'b0;
    chk("R9 clear+set keeps", irq_special, 1'b1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R9 clear", irq_special, 1'b0);

    // R10: back-to-back strobes, flow char in the middle
    spec_en = 1'b0; flow_mode = 2'b10;
    begin
      logic [DATA_W-1:0] seq [4] = '{8'h20, 8'h21, 8'h13, 8'h22};
      logic exp_p [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
      for (int k = 0; k < 4; k++) begin
        rx_valid = 1'b1; rx_data = seq[k];
        #0.5;
        chk($sformatf("R10 burst push %0d", k), push, exp_p[k]);
        if (exp_p[k]) chk($sformatf("R10 burst data %0d", k), push_data, seq[k]);
        @(negedge clk);
      end
    end
    rx_valid = 1'b0;
    chk("R10/R8 halt after burst", tx_halt, 1'b1);

    finish_run();
  end
endmodule